// File: doc/BRIEF.md
# Command and Response Transfer Engine

This block moves command bytes from a host into a shared byte buffer, hands the finished command to a backend executor, and then returns the response bytes to the host one byte at a time. Each locality has its own five-state sequence: idle, ready, receiving, executing and response-ready. All localities share a single buffer and a single read/write offset. A host access counts only when it comes from the locality that is currently active. Choosing the active locality is done outside this block.

The host uses three kinds of access. A byte write pushes command data. A byte read pops response data. A control write carries one of three strobes: command-ready, go or retry, and each strobe has a different effect in each state. The block knows a command is complete by reading the big-endian 32-bit length stored in buffer bytes 2 to 5, once more than five bytes have arrived. Go then sends a start pulse to the backend with the byte count. The backend writes its response into the buffer and signals done. The block reports status flags and a burst count for the accessing locality, and it emits single-cycle event pulses.

Top module: `xfer_fifo_engine`

## Requirements
- R1: After reset every locality is idle with all status flags clear and the offset at zero. With no active locality, all status outputs are zero and `fifo_rdata` reads 0xFF.
- R2: An access from a locality that is not active, or that is outside the range of `NLOC` localities, changes nothing. For such an access the status, family and burst outputs read zero.
- R3: Control strobe encoding on `ctl_bits`: 3'b001 is command-ready, 3'b010 is go, 3'b100 is retry, and any other value does nothing. Command-ready in idle moves to ready, sets cmd_ready and pulses `evt_cmd_ready`. In ready it only rewinds the offset.
- R4: In ready, the first data byte moves the locality to receiving with expect and valid set. Data writes in idle, executing or response-ready are dropped.
- R5: Bytes 2 to 5 of the buffer hold the command length, most significant byte first. Once the offset exceeds 5 and expect is set, expect stays set while the length is larger than the offset and clears when they match.
- R6: Go in receiving with expect clear sends one `be_start` pulse, with `be_len` equal to the number of bytes received and `be_loc` equal to the locality, and the locality moves to executing. Go in any other case is ignored.
- R7: `be_done` moves the executing locality to response-ready with valid and data-available set, rewinds the offset, and pulses `evt_valid` and `evt_avail`.
- R8: In response-ready with data-available set, reads return the response bytes in order. After the last byte only valid stays set. Every other read returns 0xFF.
- R9: Retry in response-ready rewinds the offset and sets valid and data-available again.
- R10: `burst_count` is the response length minus the offset while data is available, and the buffer size minus the offset otherwise. The response length is the header length, capped at `BUF`. `burst_byte` is the same value saturated at 0xFF.
- R11: A byte that arrives when the buffer is full is not stored and leaves only valid set.
- R12: Command-ready in receiving aborts the command: the locality returns to ready with cmd_ready set and the offset at zero. In executing it pulses `be_cancel`, and the following `be_done` lands the locality in ready with cmd_ready set instead of response-ready.
- R13: Command-ready in response-ready returns the locality to ready, rewinds the offset and clears data-available.
- R14: Any status update keeps the self-test flag, which a done carrying `be_selftest` sets and only reset clears. `st_family` always shows the `FAMILY` parameter for the active locality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_vld | input | 1 | A locality is active |
| active_loc | input | LW | Active locality number |
| acc_loc | input | LW | Locality of the current host access |
| fifo_wr | input | 1 | Host writes one data byte |
| fifo_wdata | input | 8 | Data byte to write |
| fifo_rd | input | 1 | Host reads one data byte |
| fifo_rdata | output | 8 | Read byte; 0xFF when no data |
| ctl_wr | input | 1 | Host control write |
| ctl_bits | input | 3 | Control strobe value |
| st_valid | output | 1 | Status valid flag |
| st_expect | output | 1 | More command bytes expected |
| st_avail | output | 1 | Response data available |
| st_cmd_ready | output | 1 | Ready for a command |
| st_selftest | output | 1 | Sticky self-test-done flag |
| st_family | output | 2 | Family field |
| burst_count | output | OW | Bytes that can be moved now |
| burst_byte | output | 8 | Burst count saturated to one byte |
| be_start | output | 1 | Start pulse to the backend |
| be_len | output | OW | Command length given with the start pulse |
| be_loc | output | LW | Locality of the started command |
| be_cancel | output | 1 | Cancel request pulse |
| be_wr | input | 1 | Backend writes a response byte |
| be_waddr | input | OW | Response byte address |
| be_wdata | input | 8 | Response byte |
| be_done | input | 1 | Backend finished |
| be_selftest | input | 1 | Self-test finished, sampled with done |
| evt_cmd_ready | output | 1 | Command-ready event pulse |
| evt_valid | output | 1 | Valid event pulse |
| evt_avail | output | 1 | Data-available event pulse |
| evt_loc | output | LW | Locality of the event |

## Verification
The assertions assume that at most one of `ctl_wr`, `fifo_wr` and `fifo_rd` is high in any cycle. They also assume that `be_done` arrives only while a command is executing and never in the same cycle as a host access, and that the backend writes the buffer only between start and done. The stimulus follows these rules because each task raises one strobe for a single cycle and drops it. Backend loading and done are issued only after a start pulse or a cancel has been observed. The invariants that are checked are: expect implies valid, data-available excludes expect and cmd_ready, a read with no data returns 0xFF, and start and cancel follow only their own control strobe.

// File: rtl/xfer_fsm_pkg.sv
package xfer_fsm_pkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_READY,
    XS_RECV,
    XS_EXEC,
    XS_DONE
  } xstate_e;

  typedef struct packed {
    logic selftest;
    logic valid;
    logic expect_more;
    logic avail;
    logic cmd_rdy;
  } xsts_t;

  localparam logic [2:0] CTL_CMD_READY = 3'b001;
  localparam logic [2:0] CTL_GO        = 3'b010;
  localparam logic [2:0] CTL_RETRY     = 3'b100;
  localparam logic [7:0] NO_DATA_BYTE  = 8'hFF;

  // Replace all status flags except the sticky self-test flag.
  function automatic xsts_t sts_set(xsts_t cur, logic v, logic e, logic a, logic c);
    xsts_t r;
    r.selftest    = cur.selftest;
    r.valid       = v;
    r.expect_more = e;
    r.avail       = a;
    r.cmd_rdy     = c;
    return r;
  endfunction

endpackage

// File: rtl/xfer_cmd_buf.sv
module xfer_cmd_buf #(
  parameter int BUF = 256,
  parameter int OW  = 9,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [OW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic [31:0]   hdr_now,
  output logic [31:0]   hdr_q
);

  localparam logic [OW-1:0] BUF_W = OW'(BUF);

  logic [7:0] mem [BUF];

  always_ff @(posedge clk) begin
    if (wr_en && (waddr < BUF_W)) begin
      mem[waddr[AW-1:0]] <= wdata;
    end
  end

  assign rdata = (raddr < BUF_W) ? mem[raddr[AW-1:0]] : 8'hFF;

  // Header length bytes sit at addresses 2..5, most significant first.
  for (genvar k = 0; k < 4; k++) begin : g_hdr
    localparam logic [OW-1:0] POS = OW'(2 + k);
    assign hdr_now[31-8*k -: 8] = (wr_en && (waddr == POS)) ? wdata : hdr_q[31-8*k -: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
    end else if (wr_en) begin
      hdr_q <= hdr_now;
    end
  end

endmodule

// File: rtl/xfer_burst.sv
module xfer_burst #(
  parameter int BUF = 256,
  parameter int OW  = 9
) (
  input  logic          avail,
  input  logic [OW-1:0] off,
  input  logic [OW-1:0] rlen,
  output logic [OW-1:0] cnt,
  output logic [7:0]    cnt_byte
);

  localparam logic [OW-1:0] BUF_W = OW'(BUF);

  always_comb begin
    if (avail) begin
      cnt = (rlen > off) ? (rlen - off) : '0;
    end else begin
      cnt = (BUF_W > off) ? (BUF_W - off) : '0;
    end
  end

  if (OW > 8) begin : g_sat
    assign cnt_byte = (cnt > OW'(255)) ? 8'hFF : cnt[7:0];
  end else if (OW == 8) begin : g_eq
    assign cnt_byte = cnt;
  end else begin : g_ext
    assign cnt_byte = {{(8-OW){1'b0}}, cnt};
  end

endmodule

// File: rtl/xfer_fifo_engine.sv
module xfer_fifo_engine #(
  parameter int           NLOC   = 4,
  parameter int           BUF    = 256,
  parameter logic [1:0]   FAMILY = 2'b01,
  localparam int          LW     = (NLOC > 1) ? $clog2(NLOC) : 1,
  localparam int          OW     = $clog2(BUF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_vld,
  input  logic [LW-1:0] active_loc,
  input  logic [LW-1:0] acc_loc,
  input  logic          fifo_wr,
  input  logic [7:0]    fifo_wdata,
  input  logic          fifo_rd,
  output logic [7:0]    fifo_rdata,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_bits,
  output logic          st_valid,
  output logic          st_expect,
  output logic          st_avail,
  output logic          st_cmd_ready,
  output logic          st_selftest,
  output logic [1:0]    st_family,
  output logic [OW-1:0] burst_count,
  output logic [7:0]    burst_byte,
  output logic          be_start,
  output logic [OW-1:0] be_len,
  output logic [LW-1:0] be_loc,
  output logic          be_cancel,
  input  logic          be_wr,
  input  logic [OW-1:0] be_waddr,
  input  logic [7:0]    be_wdata,
  input  logic          be_done,
  input  logic          be_selftest,
  output logic          evt_cmd_ready,
  output logic          evt_valid,
  output logic          evt_avail,
  output logic [LW-1:0] evt_loc
);
  import xfer_fsm_pkg::*;

  localparam int            AW    = (BUF > 1) ? $clog2(BUF) : 1;
  localparam logic [OW-1:0] BUF_W = OW'(BUF);

  // Per-locality state
  xstate_e st_all  [NLOC];
  xsts_t   sts_all [NLOC];

  // Shared state
  logic [OW-1:0] off_q, off_d;
  logic [LW-1:0] exec_q, exec_d;
  logic          abort_q, abort_d;
  logic          start_q, start_d;
  logic [OW-1:0] len_q;
  logic          cancel_q, cancel_d;
  logic          ecr_q, ecr_d, ev_q, ev_d, ea_q, ea_d;
  logic [LW-1:0] eloc_q, eloc_d;

  // Single locality update port
  logic          ld_en;
  logic [LW-1:0] ld_idx;
  xstate_e       cs;
  xsts_t         ss;

  // Access decode
  logic          hit;
  logic [LW-1:0] acc_idx;
  xstate_e       cur_st;
  xsts_t         cur_sts;

  assign hit     = active_vld && (acc_loc == active_loc) && (32'(acc_loc) < NLOC);
  assign acc_idx = hit ? acc_loc : '0;
  assign cur_st  = st_all[acc_idx];
  assign cur_sts = sts_all[acc_idx];

  // Buffer ports
  logic          host_store;
  logic          buf_we;
  logic [OW-1:0] buf_wa;
  logic [7:0]    buf_wd;
  logic [7:0]    buf_rd;
  logic [31:0]   hdr_now, hdr_q;
  logic [OW-1:0] rlen;

  assign host_store = hit && !be_done && !ctl_wr && fifo_wr && (off_q < BUF_W) &&
                      ((cur_st == XS_READY) || ((cur_st == XS_RECV) && cur_sts.expect_more));
  assign buf_we = be_wr || host_store;
  assign buf_wa = be_wr ? be_waddr : off_q;
  assign buf_wd = be_wr ? be_wdata : fifo_wdata;

  xfer_cmd_buf #(.BUF(BUF), .OW(OW), .AW(AW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_we),
    .waddr   (buf_wa),
    .wdata   (buf_wd),
    .raddr   (off_q),
    .rdata   (buf_rd),
    .hdr_now (hdr_now),
    .hdr_q   (hdr_q)
  );

  assign rlen = (hdr_q > 32'(BUF)) ? BUF_W : hdr_q[OW-1:0];

  // Next-state logic
  logic need_evt;

  always_comb begin
    ld_en    = 1'b0;
    ld_idx   = acc_idx;
    cs       = cur_st;
    ss       = cur_sts;
    off_d    = off_q;
    exec_d   = exec_q;
    abort_d  = abort_q;
    start_d  = 1'b0;
    cancel_d = 1'b0;
    ecr_d    = 1'b0;
    ev_d     = 1'b0;
    ea_d     = 1'b0;
    eloc_d   = acc_idx;
    need_evt = 1'b0;
    if (be_done) begin
      ld_en       = 1'b1;
      ld_idx      = exec_q;
      eloc_d      = exec_q;
      ss          = sts_all[exec_q];
      ss.selftest = ss.selftest | be_selftest;
      off_d       = '0;
      abort_d     = 1'b0;
      if (abort_q) begin
        cs    = XS_READY;
        ss    = sts_set(ss, 1'b0, 1'b0, 1'b0, 1'b1);
        ecr_d = 1'b1;
      end else begin
        cs    = XS_DONE;
        ss    = sts_set(ss, 1'b1, 1'b0, 1'b1, 1'b0);
        ev_d  = 1'b1;
        ea_d  = 1'b1;
      end
    end else if (hit) begin
      if (ctl_wr) begin
        case (ctl_bits)
          CTL_CMD_READY: begin
            case (cur_st)
              XS_IDLE: begin
                ld_en = 1'b1;
                cs    = XS_READY;
                ss    = sts_set(cur_sts, 1'b0, 1'b0, 1'b0, 1'b1);
                ecr_d = 1'b1;
              end
              XS_READY: off_d = '0;
              XS_RECV: begin
                ld_en = 1'b1;
                cs    = XS_READY;
                off_d = '0;
                ss    = sts_set(cur_sts, 1'b0, 1'b0, 1'b0, 1'b1);
                ecr_d = 1'b1;
              end
              XS_EXEC: begin
                cancel_d = 1'b1;
                abort_d  = 1'b1;
              end
              XS_DONE: begin
                ld_en = 1'b1;
                cs    = XS_READY;
                off_d = '0;
                ss    = sts_set(cur_sts, 1'b0, 1'b0, 1'b0, 1'b1);
                ecr_d = !cur_sts.cmd_rdy;
              end
              default: ;
            endcase
          end
          CTL_GO: begin
            if ((cur_st == XS_RECV) && !cur_sts.expect_more) begin
              ld_en   = 1'b1;
              cs      = XS_EXEC;
              start_d = 1'b1;
              exec_d  = acc_idx;
            end
          end
          CTL_RETRY: begin
            if (cur_st == XS_DONE) begin
              ld_en = 1'b1;
              off_d = '0;
              ss    = sts_set(cur_sts, 1'b1, 1'b0, 1'b1, 1'b0);
            end
          end
          default: ;
        endcase
      end else if (fifo_wr) begin
        if ((cur_st == XS_READY) || (cur_st == XS_RECV)) begin
          ld_en = 1'b1;
          if (cur_st == XS_READY) begin
            cs = XS_RECV;
            ss = sts_set(cur_sts, 1'b1, 1'b1, 1'b0, 1'b0);
          end
          if (ss.expect_more) begin
            if (host_store) begin
              off_d = off_q + 1'b1;
              if (off_d > OW'(5)) begin
                need_evt = !ss.valid;
                if (hdr_now > 32'(off_d)) begin
                  ss = sts_set(ss, 1'b1, 1'b1, 1'b0, 1'b0);
                end else begin
                  ss = sts_set(ss, 1'b1, 1'b0, 1'b0, 1'b0);
                end
                ev_d = need_evt;
              end
            end else begin
              ss = sts_set(ss, 1'b1, 1'b0, 1'b0, 1'b0);
            end
          end
        end
      end else if (fifo_rd) begin
        if ((cur_st == XS_DONE) && cur_sts.avail) begin
          off_d = off_q + 1'b1;
          if (off_d >= rlen) begin
            ld_en = 1'b1;
            ss    = sts_set(cur_sts, 1'b1, 1'b0, 1'b0, 1'b0);
            ev_d  = 1'b1;
          end
        end
      end
    end
  end

  // Per-locality registers
  for (genvar l = 0; l < NLOC; l++) begin : g_loc
    xstate_e st_r;
    xsts_t   sts_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= XS_IDLE;
        sts_r <= '0;
      end else if (ld_en && (ld_idx == LW'(l))) begin
        st_r  <= cs;
        sts_r <= ss;
      end
    end
    assign st_all[l]  = st_r;
    assign sts_all[l] = sts_r;
  end

  // Shared registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q    <= '0;
      exec_q   <= '0;
      abort_q  <= 1'b0;
      start_q  <= 1'b0;
      len_q    <= '0;
      cancel_q <= 1'b0;
      ecr_q    <= 1'b0;
      ev_q     <= 1'b0;
      ea_q     <= 1'b0;
      eloc_q   <= '0;
    end else begin
      off_q    <= off_d;
      exec_q   <= exec_d;
      abort_q  <= abort_d;
      start_q  <= start_d;
      cancel_q <= cancel_d;
      ecr_q    <= ecr_d;
      ev_q     <= ev_d;
      ea_q     <= ea_d;
      eloc_q   <= eloc_d;
      if (start_d) begin
        len_q <= off_q;
      end
    end
  end

  // Status and burst
  logic [OW-1:0] cnt;
  logic [7:0]    cnt_byte;

  xfer_burst #(.BUF(BUF), .OW(OW)) u_burst (
    .avail    (cur_sts.avail),
    .off      (off_q),
    .rlen     (rlen),
    .cnt      (cnt),
    .cnt_byte (cnt_byte)
  );

  assign st_valid     = hit && cur_sts.valid;
  assign st_expect    = hit && cur_sts.expect_more;
  assign st_avail     = hit && cur_sts.avail;
  assign st_cmd_ready = hit && cur_sts.cmd_rdy;
  assign st_selftest  = hit && cur_sts.selftest;
  assign st_family    = hit ? FAMILY : 2'b00;
  assign burst_count  = hit ? cnt : '0;
  assign burst_byte   = hit ? cnt_byte : 8'h00;
  assign fifo_rdata   = (hit && (cur_st == XS_DONE) && cur_sts.avail) ? buf_rd : NO_DATA_BYTE;

  assign be_start      = start_q;
  assign be_len        = len_q;
  assign be_loc        = exec_q;
  assign be_cancel     = cancel_q;
  assign evt_cmd_ready = ecr_q;
  assign evt_valid     = ev_q;
  assign evt_avail     = ea_q;
  assign evt_loc       = eloc_q;

endmodule

// File: rtl/xfer_fifo_engine_chk.sv
module xfer_fifo_engine_chk #(
  parameter int BUF = 256,
  localparam int OW = $clog2(BUF + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_rd,
  input logic [7:0]    fifo_rdata,
  input logic          ctl_wr,
  input logic [2:0]    ctl_bits,
  input logic          st_valid,
  input logic          st_expect,
  input logic          st_avail,
  input logic          st_cmd_ready,
  input logic          be_start,
  input logic [OW-1:0] be_len,
  input logic          be_cancel
);

  AST_EXPECT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    st_expect |-> st_valid); // R4

  AST_AVAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    st_avail |-> (!st_expect && !st_cmd_ready)); // R7

  AST_NODATA_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !st_avail) |-> (fifo_rdata == 8'hFF)); // R8

  AST_START_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> $past(ctl_wr && (ctl_bits == 3'b010))); // R6

  AST_START_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> (be_len > OW'(5))); // R5

  AST_CANCEL_AFTER_CR: assert property (@(posedge clk) disable iff (!rst_n)
    be_cancel |-> $past(ctl_wr && (ctl_bits == 3'b001))); // R12

endmodule

bind xfer_fifo_engine xfer_fifo_engine_chk #(.BUF(BUF)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_rd      (fifo_rd),
  .fifo_rdata   (fifo_rdata),
  .ctl_wr       (ctl_wr),
  .ctl_bits     (ctl_bits),
  .st_valid     (st_valid),
  .st_expect    (st_expect),
  .st_avail     (st_avail),
  .st_cmd_ready (st_cmd_ready),
  .be_start     (be_start),
  .be_len       (be_len),
  .be_cancel    (be_cancel)
);

// File: tb/xfer_fifo_engine_tb_top.sv
`timescale 1ns/1ps
module xfer_fifo_engine_tb_top;

  localparam int         NL  = 3;
  localparam int         BF  = 32;
  localparam int         OWS = 6;
  localparam int         BB  = 300;
  localparam int         OWB = 9;
  localparam logic [1:0] FAM = 2'b10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n;
  logic           active_vld;
  logic [1:0]     active_loc, acc_loc;
  logic           fifo_wr, fifo_rd, ctl_wr;
  logic [7:0]     fifo_wdata;
  logic [2:0]     ctl_bits;
  logic           be_wr, be_done, be_selftest;
  logic [OWS-1:0] be_waddr;
  logic [7:0]     be_wdata;

  logic [7:0]     fifo_rdata;
  logic           st_valid, st_expect, st_avail, st_cmd_ready, st_selftest;
  logic [1:0]     st_family;
  logic [OWS-1:0] burst_count;
  logic [7:0]     burst_byte;
  logic           be_start, be_cancel;
  logic [OWS-1:0] be_len;
  logic [1:0]     be_loc;
  logic           evt_cmd_ready, evt_valid, evt_avail;
  logic [1:0]     evt_loc;

  xfer_fifo_engine #(.NLOC(NL), .BUF(BF), .FAMILY(FAM)) dut_i (
    .clk(clk), .rst_n(rst_n), .active_vld(active_vld), .active_loc(active_loc),
    .acc_loc(acc_loc), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_rd(fifo_rd),
    .fifo_rdata(fifo_rdata), .ctl_wr(ctl_wr), .ctl_bits(ctl_bits),
    .st_valid(st_valid), .st_expect(st_expect), .st_avail(st_avail),
    .st_cmd_ready(st_cmd_ready), .st_selftest(st_selftest), .st_family(st_family),
    .burst_count(burst_count), .burst_byte(burst_byte), .be_start(be_start),
    .be_len(be_len), .be_loc(be_loc), .be_cancel(be_cancel), .be_wr(be_wr),
    .be_waddr(be_waddr), .be_wdata(be_wdata), .be_done(be_done),
    .be_selftest(be_selftest), .evt_cmd_ready(evt_cmd_ready), .evt_valid(evt_valid),
    .evt_avail(evt_avail), .evt_loc(evt_loc)
  );

  // Wide-buffer instance for the byte saturation of the burst count
  logic [7:0]     b_rdata, b_bbyte;
  logic           b_v, b_e, b_a, b_c, b_s, b_st, b_cn, b_ecr, b_ev, b_ea;
  logic [1:0]     b_fam, b_bloc, b_eloc;
  logic [OWB-1:0] b_cnt, b_len;

  xfer_fifo_engine #(.NLOC(NL), .BUF(BB), .FAMILY(FAM)) dut_big (
    .clk(clk), .rst_n(rst_n), .active_vld(active_vld), .active_loc(active_loc),
    .acc_loc(acc_loc), .fifo_wr(1'b0), .fifo_wdata(8'h00), .fifo_rd(1'b0),
    .fifo_rdata(b_rdata), .ctl_wr(1'b0), .ctl_bits(3'b000),
    .st_valid(b_v), .st_expect(b_e), .st_avail(b_a), .st_cmd_ready(b_c),
    .st_selftest(b_s), .st_family(b_fam), .burst_count(b_cnt), .burst_byte(b_bbyte),
    .be_start(b_st), .be_len(b_len), .be_loc(b_bloc), .be_cancel(b_cn),
    .be_wr(1'b0), .be_waddr('0), .be_wdata(8'h00), .be_done(1'b0),
    .be_selftest(1'b0), .evt_cmd_ready(b_ecr), .evt_valid(b_ev), .evt_avail(b_ea),
    .evt_loc(b_eloc)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] cbyte(input int i, input int len);
    if (i >= 2 && i <= 5) return 8'(len >> (8 * (5 - i)));
    return 8'(8'hA0 + i);
  endfunction

  function automatic logic [7:0] rbyte_exp(input int i, input int len);
    if (i >= 2 && i <= 5) return 8'(len >> (8 * (5 - i)));
    return 8'(8'h50 ^ i);
  endfunction

  task automatic ctl(input logic [2:0] b);
    ctl_wr = 1'b1; ctl_bits = b;
    step();
    ctl_wr = 1'b0; ctl_bits = 3'b000;
  endtask

  task automatic wbyte(input logic [7:0] b);
    fifo_wr = 1'b1; fifo_wdata = b;
    step();
    fifo_wr = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] d);
    fifo_rd = 1'b1;
    #1 d = fifo_rdata;
    step();
    fifo_rd = 1'b0;
  endtask

  task automatic be_load(input int len);
    int n;
    n = (len > BF) ? BF : len;
    for (int i = 0; i < n; i++) begin
      be_wr = 1'b1; be_waddr = OWS'(i); be_wdata = rbyte_exp(i, len);
      step();
    end
    be_wr = 1'b0;
  endtask

  task automatic done(input logic st);
    be_done = 1'b1; be_selftest = st;
    step();
    be_done = 1'b0; be_selftest = 1'b0;
  endtask

  // Full transaction on locality loc, starting in ready or idle
  task automatic run_txn(input int len, input int rsp, input int loc, input logic stf);
    int rl;
    logic [7:0] d;
    rl = (rsp > BF) ? BF : rsp;
    active_loc = 2'(loc); acc_loc = 2'(loc);
    #1;
    ctl(3'b001);
    check("R3 cmd_ready in ready", st_cmd_ready, 1);
    check("R10 burst in ready", burst_count, BF);
    for (int n = 1; n <= len; n++) begin
      wbyte(cbyte(n - 1, len));
      check("R5 expect while receiving", st_expect, ((n <= 5) || (len > n)) ? 1 : 0);
      check("R4 valid while receiving", st_valid, 1);
      check("R10 burst while receiving", burst_count, BF - n);
      check("R10 burst byte", burst_byte, BF - n);
    end
    check("R4 cmd_ready cleared", st_cmd_ready, 0);
    ctl(3'b010);
    check("R6 start pulse", be_start, 1);
    check("R6 start length", be_len, len);
    check("R6 start locality", be_loc, loc);
    step();
    check("R6 start is one pulse", be_start, 0);
    be_load(rsp);
    done(stf);
    check("R7 valid event", evt_valid, 1);
    check("R7 avail event", evt_avail, 1);
    check("R7 event locality", evt_loc, loc);
    check("R7 avail flag", st_avail, 1);
    check("R7 valid flag", st_valid, 1);
    check("R10 burst response", burst_count, rl);
    wbyte(8'h33);
    check("R4 write dropped in completion", burst_count, rl);
    for (int i = 0; i < rl; i++) begin
      rbyte(d);
      check("R8 response byte", d, rbyte_exp(i, rsp));
      check("R8 avail after read", st_avail, (i + 1 < rl) ? 1 : 0);
      check("R8 valid after read", st_valid, 1);
    end
    check("R10 burst after drain", burst_count, BF - rl);
    rbyte(d);
    check("R8 no data byte", d, 8'hFF);
    ctl(3'b100);
    check("R9 retry avail", st_avail, 1);
    check("R9 retry burst", burst_count, rl);
    rbyte(d);
    check("R9 retry first byte", d, rbyte_exp(0, rsp));
    ctl(3'b001);
    check("R13 ready after completion", st_cmd_ready, 1);
    check("R13 avail cleared", st_avail, 0);
    check("R13 offset rewound", burst_count, BF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; active_vld = 1'b0; active_loc = '0; acc_loc = '0;
    fifo_wr = 1'b0; fifo_rd = 1'b0; ctl_wr = 1'b0; fifo_wdata = '0; ctl_bits = '0;
    be_wr = 1'b0; be_done = 1'b0; be_selftest = 1'b0; be_waddr = '0; be_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 valid", st_valid, 0);
    check("R1 cmd_ready", st_cmd_ready, 0);
    check("R1 burst no locality", burst_count, 0);
    check("R1 read data", fifo_rdata, 8'hFF);
    check("R1 start", be_start, 0);
    active_vld = 1'b1; active_loc = 2'd0; acc_loc = 2'd0;
    #1;
    check("R1 burst at reset", burst_count, BF);
    check("R1 flags at reset", {st_valid, st_expect, st_avail, st_cmd_ready}, 0);
    check("R14 family", st_family, FAM);
    check("R10 wide burst", b_cnt, BB);
    check("R10 wide burst byte", b_bbyte, 8'hFF);
    // R2 non-active locality
    acc_loc = 2'd1;
    #1;
    check("R2 burst when not active", burst_count, 0);
    check("R2 family when not active", st_family, 0);
    ctl(3'b001);
    check("R2 no event", evt_cmd_ready, 0);
    acc_loc = 2'd3; active_loc = 2'd3;
    #1;
    check("R2 out of range locality", burst_count, 0);
    active_loc = 2'd1; acc_loc = 2'd1;
    #1;
    check("R2 write ignored", st_cmd_ready, 0);
    // R4 idle write dropped
    wbyte(8'h11);
    check("R4 idle drop expect", st_expect, 0);
    check("R4 idle drop burst", burst_count, BF);
    ctl(3'b010);
    check("R6 go in idle ignored", be_start, 0);
    ctl(3'b001);
    check("R3 idle to ready event", evt_cmd_ready, 1);
    check("R3 idle to ready flag", st_cmd_ready, 1);
    ctl(3'b010);
    check("R6 go in ready ignored", be_start, 0);
    ctl(3'b011);
    check("R3 mixed strobes ignored", st_cmd_ready, 1);
    run_txn(6, 6, 1, 1'b0);
    run_txn(7, 12, 1, 1'b0);
    active_loc = 2'd2; acc_loc = 2'd2;
    #1;
    ctl(3'b001);
    run_txn(10, 40, 2, 1'b1);
    check("R14 selftest set", st_selftest, 1);
    run_txn(BF, 9, 2, 1'b0);
    check("R14 selftest sticky", st_selftest, 1);
    active_loc = 2'd0; acc_loc = 2'd0;
    #1;
    ctl(3'b001);
    run_txn(20, BF, 0, 1'b0);
    check("R14 selftest per locality", st_selftest, 0);
    // R11 overflow
    for (int n = 0; n < BF; n++) wbyte(cbyte(n, 40));
    check("R11 expect before full", st_expect, 1);
    wbyte(8'h77);
    check("R11 expect after overflow", st_expect, 0);
    check("R11 valid after overflow", st_valid, 1);
    check("R11 burst when full", burst_count, 0);
    wbyte(8'h78);
    ctl(3'b010);
    check("R11 length capped", be_len, BF);
    check("R11 start", be_start, 1);
    be_load(6);
    done(1'b0);
    check("R7 done after overflow", st_avail, 1);
    ctl(3'b001);
    // R12 abort while receiving
    for (int n = 0; n < 3; n++) wbyte(cbyte(n, 10));
    ctl(3'b010);
    check("R6 go with expect set ignored", be_start, 0);
    ctl(3'b001);
    check("R12 abort recv event", evt_cmd_ready, 1);
    check("R12 abort recv ready", st_cmd_ready, 1);
    check("R12 abort recv expect", st_expect, 0);
    check("R12 abort recv offset", burst_count, BF);
    // R12 abort while executing
    for (int n = 0; n < 6; n++) wbyte(cbyte(n, 6));
    ctl(3'b010);
    check("R12 exec start", be_start, 1);
    ctl(3'b001);
    check("R12 cancel pulse", be_cancel, 1);
    done(1'b0);
    check("R12 abort done event", evt_cmd_ready, 1);
    check("R12 abort done no valid event", evt_valid, 0);
    check("R12 abort done ready", st_cmd_ready, 1);
    check("R12 abort done no avail", st_avail, 0);
    rbyte(d);
    check("R8 read in ready", d, 8'hFF);
    finished = 1'b1;
    report();
  end

endmodule